// File: doc/BRIEF.md
# Integration Reorder Buffer for Cross-Correlation

This block sits between a channelizing filter bank and a set of cross-correlation units. One integration arrives as a stream of samples with time as the outermost index. Within each time step the samples of every signal and every frequency channel appear in one of two selectable nestings. The block stores the whole integration and replays it with channel outermost, then signal, then time innermost. A correlation unit can therefore take every signal and every time sample of one channel as one contiguous burst.

Storage is split into two banks, each holding one integration. The writer fills one bank while the reader drains the other, and the two swap roles at each integration boundary. The channels are split into equal groups, one for each downstream correlation unit. Every output beat carries its channel, signal and time indices, the index of its destination group, and flags that mark the first and last beats of each group's block. Both sides use valid/ready handshakes. An input marker flags the first sample of each integration.

Top module: `ct_transposer`

## Requirements
- R1: While reset is held and just after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: With `cfg_order` = 0 the input order is time outermost, then signal, then channel innermost. Every sample appears at the output under the channel, signal and time position it was written to.
- R3: With `cfg_order` = 1 the input order is time outermost, then channel, then signal innermost. Every sample appears at the output under the channel, signal and time position it was written to.
- R4: For one integration the output runs channel outermost, then signal, then time innermost. Each beat reports its indices on `out_chan`, `out_sig` and `out_time`.
- R5: `out_dest` equals `out_chan` divided by the number of channels per group (C/K).
- R6: `out_first` is 1 only on the beat with signal 0, time 0 and a channel that is the first of its group. `out_last` is 1 only on the beat with signal S-1, time T-1 and a channel that is the last of its group.
- R7: A second integration is accepted with no stall while the first one is still waiting to drain.
- R8: When both banks hold unread integrations, `in_ready` is 0. No sample is dropped or overwritten, so every integration is later emitted complete.
- R9: `cfg_order` is sampled only with the first sample of an integration. A change during the integration does not alter how that integration is stored.
- R10: A sample accepted between integrations without `in_sof` = 1 is discarded and never appears at the output. A sample with `in_sof` = 1 starts an integration.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output beat and its indices stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_order | input | 1 | Input nesting: 0 channel innermost, 1 signal innermost |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with `in_valid` |
| in_data | input | DW (8) | Input sample |
| in_sof | input | 1 | First sample of an integration |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DW (8) | Output sample |
| out_chan | output | log2(C) (2) | Channel index |
| out_sig | output | log2(S) (1) | Signal index |
| out_time | output | log2(T) (2) | Time index |
| out_dest | output | log2(K) (1) | Destination group index |
| out_first | output | 1 | First beat of a group's block |
| out_last | output | 1 | Last beat of a group's block |

## Verification
The assertions check on every cycle that a stalled output beat holds, that the writer and reader never use the same bank in the same cycle, that the input stalls when both banks are full, that the latched nesting stays fixed for a whole integration, and that the first and last flags never coincide. Only the bench scenarios can show that each sample lands at the right position under both nestings. The same holds for the correct destination index and flag placement on every beat, for junk samples before the start marker being discarded, and for a back-to-back pair of integrations under a blocked output losing nothing once the output is released.

// File: rtl/ct_pkg.sv
package ct_pkg;
    // Input nesting inside one time step
    typedef enum logic {
        ORD_CHAN_INNER = 1'b0,
        ORD_SIG_INNER  = 1'b1
    } ord_e;
endpackage

// File: rtl/ct_mem.sv
module ct_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/ct_wr_seq.sv
module ct_wr_seq #(
    parameter int C = 4,
    parameter int S = 2,
    parameter int T = 4,
    localparam int CW = $clog2(C),
    localparam int SW = $clog2(S),
    localparam int TW = $clog2(T),
    localparam int AW = CW + SW + TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          sof,
    input  logic          cfg,
    output logic          keep,
    output logic          last,
    output logic [AW-1:0] addr
);
    typedef struct packed {
        logic         active;
        ct_pkg::ord_e ord;
        logic [CW-1:0] c;
        logic [SW-1:0] s;
        logic [TW-1:0] t;
    } wst_t;

    wst_t q, d;
    ct_pkg::ord_e ord_eff;
    logic c_end, s_end, t_end;

    always_comb begin
        d       = q;
        keep    = q.active | sof;
        ord_eff = q.active ? q.ord : ct_pkg::ord_e'(cfg);
        c_end   = (q.c == CW'(C - 1));
        s_end   = (q.s == SW'(S - 1));
        t_end   = (q.t == TW'(T - 1));
        last    = keep && c_end && s_end && t_end;
        addr    = {q.c, q.s, q.t};
        if (step && keep) begin
            d.ord    = ord_eff;
            d.active = !last;
            if (ord_eff == ct_pkg::ORD_CHAN_INNER) begin
                d.c = c_end ? '0 : q.c + 1'b1;
                if (c_end) d.s = s_end ? '0 : q.s + 1'b1;
            end else begin
                d.s = s_end ? '0 : q.s + 1'b1;
                if (s_end) d.c = c_end ? '0 : q.c + 1'b1;
            end
            if (c_end && s_end) d.t = t_end ? '0 : q.t + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !(step && last)) |=> $stable(q.ord)); // R9
endmodule

// File: rtl/ct_rd_seq.sv
module ct_rd_seq #(
    parameter int C = 4,
    parameter int S = 2,
    parameter int T = 4,
    parameter int K = 2,
    localparam int CW  = $clog2(C),
    localparam int SW  = $clog2(S),
    localparam int TW  = $clog2(T),
    localparam int KW  = $clog2(K),
    localparam int AW  = CW + SW + TW,
    localparam int CPG = C / K,
    localparam int GW  = $clog2(CPG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last,
    output logic [CW-1:0] chan,
    output logic [SW-1:0] sig,
    output logic [TW-1:0] tim,
    output logic [KW-1:0] dest,
    output logic          blk_first,
    output logic          blk_last
);
    localparam logic [CW-1:0] GMASK = CW'(CPG - 1);

    typedef struct packed {
        logic [CW-1:0] c;
        logic [SW-1:0] s;
        logic [TW-1:0] t;
    } rst_t;

    rst_t q, d;
    logic c_end, s_end, t_end;

    always_comb begin
        d     = q;
        c_end = (q.c == CW'(C - 1));
        s_end = (q.s == SW'(S - 1));
        t_end = (q.t == TW'(T - 1));
        last  = c_end && s_end && t_end;
        addr  = {q.c, q.s, q.t};
        chan  = q.c;
        sig   = q.s;
        tim   = q.t;
        dest  = KW'(q.c >> GW);
        blk_first = ((q.c & GMASK) == '0) && (q.s == '0) && (q.t == '0);
        blk_last  = ((q.c & GMASK) == GMASK) && s_end && t_end;
        if (step) begin
            d.t = t_end ? '0 : q.t + 1'b1;
            if (t_end) d.s = s_end ? '0 : q.s + 1'b1;
            if (t_end && s_end) d.c = c_end ? '0 : q.c + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ((S * T > 1) && blk_first) |-> !blk_last); // R6
endmodule

// File: rtl/ct_transposer.sv
module ct_transposer #(
    parameter int DW = 8,
    parameter int C  = 4,
    parameter int S  = 2,
    parameter int T  = 4,
    parameter int K  = 2,
    localparam int CW = $clog2(C),
    localparam int SW = $clog2(S),
    localparam int TW = $clog2(T),
    localparam int KW = $clog2(K),
    localparam int AW = CW + SW + TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_order,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_sof,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [CW-1:0] out_chan,
    output logic [SW-1:0] out_sig,
    output logic [TW-1:0] out_time,
    output logic [KW-1:0] out_dest,
    output logic          out_first,
    output logic          out_last
);
    typedef struct packed {
        logic [1:0]    full;
        logic          wbank;
        logic          rbank;
        logic          ov;
        logic [CW-1:0] chan;
        logic [SW-1:0] sig;
        logic [TW-1:0] tim;
        logic [KW-1:0] dest;
        logic          first;
        logic          last;
    } tst_t;

    tst_t q, d;

    logic          in_fire, we, rd_go;
    logic          wr_keep, wr_last, rd_last;
    logic [AW-1:0] wr_off, rd_off;
    logic [CW-1:0] rd_chan;
    logic [SW-1:0] rd_sig;
    logic [TW-1:0] rd_tim;
    logic [KW-1:0] rd_dest;
    logic          rd_first, rd_blast;

    ct_wr_seq #(.C(C), .S(S), .T(T)) u_wr (
        .clk(clk), .rst_n(rst_n), .step(in_fire), .sof(in_sof),
        .cfg(cfg_order), .keep(wr_keep), .last(wr_last), .addr(wr_off)
    );

    ct_rd_seq #(.C(C), .S(S), .T(T), .K(K)) u_rd (
        .clk(clk), .rst_n(rst_n), .step(rd_go), .addr(rd_off), .last(rd_last),
        .chan(rd_chan), .sig(rd_sig), .tim(rd_tim), .dest(rd_dest),
        .blk_first(rd_first), .blk_last(rd_blast)
    );

    ct_mem #(.DW(DW), .DEPTH(2 << AW)) u_mem (
        .clk(clk), .we(we), .waddr({q.wbank, wr_off}), .wdata(in_data),
        .re(rd_go), .raddr({q.rbank, rd_off}), .rdata(out_data)
    );

    always_comb begin
        d        = q;
        in_ready = !q.full[q.wbank];
        in_fire  = in_valid && in_ready;
        we       = in_fire && wr_keep;
        rd_go    = q.full[q.rbank] && (!q.ov || out_ready);
        if (we && wr_last) begin
            d.full[q.wbank] = 1'b1;
            d.wbank         = ~q.wbank;
        end
        if (rd_go && rd_last) begin
            d.full[q.rbank] = 1'b0;
            d.rbank         = ~q.rbank;
        end
        if (rd_go) begin
            d.ov    = 1'b1;
            d.chan  = rd_chan;
            d.sig   = rd_sig;
            d.tim   = rd_tim;
            d.dest  = rd_dest;
            d.first = rd_first;
            d.last  = rd_blast;
        end else if (out_ready) begin
            d.ov = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.ov;
    assign out_chan  = q.chan;
    assign out_sig   = q.sig;
    assign out_time  = q.tim;
    assign out_dest  = q.dest;
    assign out_first = q.first;
    assign out_last  = q.last;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)
                                       && $stable(out_sig) && $stable(out_time))); // R11
    AST_BANKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rd_go) |-> (q.wbank != q.rbank)); // R7
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full == 2'b11) |-> !in_ready); // R8
endmodule

// File: tb/ct_transposer_tb.sv
module ct_transposer_tb;
    localparam int DW = 8, C = 4, S = 2, T = 4, K = 2;
    localparam int CPG = C / K;
    localparam int BEATS = C * S * T;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_order = 1'b0, in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, out_valid, out_first, out_last;
    logic [DW-1:0] out_data;
    logic [1:0] out_chan, out_time;
    logic out_sig, out_dest;

    int n_chk = 0, n_err = 0, cyc = 0, stalls = 0;
    int exp_ids [16];
    int n_int = 0, cur = 0, beat = 0, beats_seen = 0;
    bit hold = 1'b0, done = 1'b0;

    always #4 clk = ~clk;

    ct_transposer #(.DW(DW), .C(C), .S(S), .T(T), .K(K)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_order(cfg_order), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_chan(out_chan), .out_sig(out_sig), .out_time(out_time),
        .out_dest(out_dest), .out_first(out_first), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Output collector: checks every presented beat, stalled beats included (R11)
    always @(negedge clk) begin
        cyc++;
        if (rst_n && out_valid) begin
            if (cur >= n_int) begin
                chk(1'b0, "R10 unexpected output beat", int'(out_data), -1);
            end else begin
                int c, s, t;
                c = beat / (S * T); s = (beat / T) % S; t = beat % T;
                // R2 R3: data encodes the position it was written to
                chk(int'(out_data) == exp_ids[cur] * 32 + beat, "R2/R3 data", int'(out_data), exp_ids[cur] * 32 + beat);
                chk(int'(out_chan) == c && int'(out_sig) == s && int'(out_time) == t, "R4 indices",
                    int'(out_chan) * 100 + int'(out_sig) * 10 + int'(out_time), c * 100 + s * 10 + t);
                chk(int'(out_dest) == c / CPG, "R5 dest", int'(out_dest), c / CPG);
                chk(out_first == (c % CPG == 0 && s == 0 && t == 0) &&
                    out_last == (c % CPG == CPG - 1 && s == S - 1 && t == T - 1), "R6 flags",
                    int'({out_first, out_last}),
                    int'({(c % CPG == 0 && s == 0 && t == 0), (c % CPG == CPG - 1 && s == S - 1 && t == T - 1)}));
            end
        end
        out_ready = hold ? 1'b0 : (cyc % 3 != 2);
        if (rst_n && out_valid && out_ready && cur < n_int) begin
            beats_seen++;
            if (beat == BEATS - 1) begin beat = 0; cur++; end
            else beat++;
        end
    end

    task automatic send(input int v, input bit sof);
        in_data = DW'(v); in_sof = sof; in_valid = 1'b1;
        while (!in_ready) begin stalls++; @(negedge clk); end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic send_integ(input int id, input bit mode, input bit flip);
        bit first = 1'b1;
        exp_ids[n_int] = id; n_int++;
        cfg_order = mode;
        for (int t = 0; t < T; t++) begin
            if (!mode) begin
                for (int s = 0; s < S; s++)
                    for (int c = 0; c < C; c++) begin
                        send(id * 32 + c * 8 + s * 4 + t, first);
                        if (first && flip) cfg_order = !mode;
                        first = 1'b0;
                    end
            end else begin
                for (int c = 0; c < C; c++)
                    for (int s = 0; s < S; s++) begin
                        send(id * 32 + c * 8 + s * 4 + t, first);
                        if (first && flip) cfg_order = !mode;
                        first = 1'b0;
                    end
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            if (beats_seen == n_int * BEATS && !out_valid) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 in reset", int'({out_valid, in_ready}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", int'({out_valid, in_ready}), 1);

        // R2 then R3, back to back
        send_integ(0, 1'b0, 1'b0);
        send_integ(1, 1'b1, 1'b0);
        drain();

        // R7 and R8: output blocked, two integrations fill both banks
        hold = 1'b1;
        send_integ(2, 1'b0, 1'b0);
        stalls = 0;
        send_integ(3, 1'b1, 1'b0);
        chk(stalls == 0, "R7 second integration stalled", stalls, 0);
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R8 ready with both banks full", int'(in_ready), 0);
        hold = 1'b0;
        send_integ(4, 1'b0, 1'b0);
        drain();
        chk(beats_seen == 5 * BEATS, "R8 no beat lost", beats_seen, 5 * BEATS);

        // R9: nesting flipped after first sample
        send_integ(5, 1'b1, 1'b1);
        // R10: junk before the start marker
        send(8'hFF, 1'b0);
        send(8'hEE, 1'b0);
        send_integ(6, 1'b0, 1'b0);
        drain();
        chk(beats_seen == 7 * BEATS, "R10 R9 beat total", beats_seen, 7 * BEATS);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule